// File: doc/BRIEF.md
# I2C Potentiometer Register Write Controller

This block is the serial write front end of a two-channel, 64-position digital potentiometer. It listens on an I2C bus as a slave. SCL and SDA are sampled through synchronisers, and the open-drain SDA output is modelled as a drive-low enable. A write carries three bytes. The first is a slave address that must match a fixed device-type prefix and four strapped address pins. The second is an instruction that names an operation, a register and a potentiometer. The third is a data byte for the register that was chosen.

There are two kinds of register. A volatile wiper register takes the new position as soon as the data byte is acknowledged. A non-volatile data register is only armed by the data byte. The STOP that closes the transaction starts a programming interval of fixed length. The register takes its new value when that interval ends. For the whole interval the block raises a busy flag and does not pull SDA low at all. A host can therefore poll: it sends START and the address again and again until an acknowledge returns.

A START or STOP that cuts into a byte abandons the transaction without touching any register. An undefined instruction is refused, and the block then ignores the rest of that transaction.

Top module: `dpot_i2c_wr`

## Requirements
- R1: After reset all wiper and data registers read zero, busy is low and SDA is not driven.
- R2: The address byte is acknowledged only when bits 7:5 equal the device-type parameter (default 3'b010), bits 4:1 equal the address pins, and bit 0 (read/write) is 0. Any other address byte gets no acknowledge.
- R3: The instruction byte holds the opcode in bits 7:4, the register select in bits 3:2 and the potentiometer select in bits 1:0. Opcode 4'b1010 writes the wiper register and opcode 4'b1100 writes a non-volatile data register. A valid instruction is acknowledged, and so is the data byte that follows it.
- R4: An instruction with any other opcode, or with a potentiometer select of 2 or above, gets no acknowledge. Later bytes of the same transaction get none either, and no register changes.
- R5: A wiper write updates the selected wiper on the same clock edge at which the data acknowledge starts. The new value is the low 6 bits of the data byte, and bits 7:6 have no effect.
- R6: After a complete data-register write, the STOP raises busy for exactly PROG_CYCLES clock cycles. The selected register keeps its old value until the edge at which busy falls, and takes the low 6 bits of the data byte on that edge.
- R7: While busy is high the block drives SDA low for no byte, including its own address. Once busy has fallen, its address is acknowledged again.
- R8: A START or STOP that arrives part way through a byte ends the transaction with no register change. A START also begins a new transaction at once.
- R9: SDA is driven low only in acknowledge slots, and never while the master is sending data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low_o | output | 1 | Pull SDA low when high |
| addr_pins_i | input | 4 | Strapped address bits compared with address bits 4:1 |
| wiper_o | output | NUM_POTS*WIPER_W | Wiper positions, potentiometer p at bits p*WIPER_W upward |
| nvreg_o | output | NUM_POTS*4*WIPER_W | Data registers, register r of potentiometer p at slot p*4+r |
| busy_o | output | 1 | Programming interval running |

## Verification
Two functions can meet in the same cycle: the end of the programming interval and a polling START with its address from the host. The bench keeps polling without a gap after a data-register write, so a poll lands close to the moment busy falls. It then judges three things. Every poll that starts while busy is high must find SDA released in the acknowledge slot. The first acknowledged poll must see busy already low and the committed register holding its new value. The number of busy-high cycles must equal the programmed length exactly.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_ACK, ST_HOLD} bus_st_t;
   typedef enum logic [1:0] {PH_ADDR, PH_INSTR, PH_DATA} phase_t;
   localparam logic [3:0] OP_WIPER = 4'b1010;
   localparam logic [3:0] OP_DREG  = 4'b1100;
   localparam int         NV_PER_POT = 4;
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p,
   output logic sda_lvl
);
   localparam int DEPTH = SYNC_STAGES + 1;

   logic [DEPTH-1:0] scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
      end else begin
         scl_q <= {scl_q[DEPTH-2:0], scl_i};
         sda_q <= {sda_q[DEPTH-2:0], sda_i};
      end
   end

   logic scl_now, scl_was, sda_now, sda_was;
   assign scl_now = scl_q[DEPTH-2];
   assign scl_was = scl_q[DEPTH-1];
   assign sda_now = sda_q[DEPTH-2];
   assign sda_was = sda_q[DEPTH-1];

   assign scl_rise = scl_now & ~scl_was;
   assign scl_fall = ~scl_now & scl_was;
   assign start_p  = scl_now & scl_was & sda_was & ~sda_now;
   assign stop_p   = scl_now & scl_was & ~sda_was & sda_now;
   assign sda_lvl  = sda_now;
endmodule

// File: rtl/dpot_xfer_fsm.sv
module dpot_xfer_fsm
   import dpot_pkg::*;
#(
   parameter int         WIPER_W  = 6,
   parameter int         NUM_POTS = 2,
   parameter logic [2:0] DEV_TYPE = 3'b010
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_p,
   input  logic               stop_p,
   input  logic               sda_lvl,
   input  logic               busy,
   input  logic [3:0]         addr_pins,
   output logic               sda_low,
   output logic               vol_we,
   output logic [WIPER_W-1:0] vol_data,
   output logic               nv_go,
   output logic [1:0]         tgt_pot,
   output logic [1:0]         tgt_sel,
   output logic [WIPER_W-1:0] nv_data
);
   bus_st_t            st;
   phase_t             ph;
   logic [7:0]         sh;
   logic [3:0]         cnt;
   logic [3:0]         op_q;
   logic [1:0]         sel_q, pot_q;
   logic [WIPER_W-1:0] data_q;
   logic               nv_pend;

   logic byte_done, addr_ok, instr_ok, byte_ack;

   assign byte_done = (st == ST_RX) && scl_fall && (cnt == 4'd8);
   assign addr_ok   = (sh[7:5] == DEV_TYPE) && (sh[4:1] == addr_pins) && !sh[0];
   assign instr_ok  = ((sh[7:4] == OP_WIPER) || (sh[7:4] == OP_DREG))
                      && (int'(sh[1:0]) < NUM_POTS);

   always_comb begin
      case (ph)
         PH_ADDR:  byte_ack = addr_ok;
         PH_INSTR: byte_ack = instr_ok;
         default:  byte_ack = 1'b1;
      endcase
   end

   assign vol_we   = byte_done && (ph == PH_DATA) && (op_q == OP_WIPER);
   assign vol_data = sh[WIPER_W-1:0];
   assign nv_go    = stop_p && nv_pend && !busy;
   assign tgt_pot  = pot_q;
   assign tgt_sel  = sel_q;
   assign nv_data  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         ph      <= PH_ADDR;
         sh      <= '0;
         cnt     <= '0;
         op_q    <= '0;
         sel_q   <= '0;
         pot_q   <= '0;
         data_q  <= '0;
         nv_pend <= 1'b0;
         sda_low <= 1'b0;
      end else if (start_p) begin
         st      <= busy ? ST_IDLE : ST_RX;
         ph      <= PH_ADDR;
         cnt     <= '0;
         nv_pend <= 1'b0;
         sda_low <= 1'b0;
      end else if (stop_p) begin
         st      <= ST_IDLE;
         nv_pend <= 1'b0;
         sda_low <= 1'b0;
      end else begin
         case (st)
            ST_RX: begin
               if (scl_rise && (cnt < 4'd8)) begin
                  sh  <= {sh[6:0], sda_lvl};
                  cnt <= cnt + 4'd1;
               end
               if (byte_done) begin
                  if (byte_ack) begin
                     sda_low <= 1'b1;
                     st      <= ST_ACK;
                     if (ph == PH_INSTR) begin
                        op_q  <= sh[7:4];
                        sel_q <= sh[3:2];
                        pot_q <= sh[1:0];
                     end
                     if (ph == PH_DATA) begin
                        data_q  <= sh[WIPER_W-1:0];
                        nv_pend <= (op_q == OP_DREG);
                     end
                  end else begin
                     st <= ST_IDLE;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_low <= 1'b0;
                  cnt     <= '0;
                  case (ph)
                     PH_ADDR:  begin ph <= PH_INSTR; st <= ST_RX; end
                     PH_INSTR: begin ph <= PH_DATA;  st <= ST_RX; end
                     default:  st <= ST_HOLD;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dpot_prog_timer.sv
module dpot_prog_timer #(
   parameter int WIPER_W     = 6,
   parameter int PROG_CYCLES = 1250000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic [1:0]         pot_in,
   input  logic [1:0]         sel_in,
   input  logic [WIPER_W-1:0] data_in,
   output logic               busy,
   output logic               commit,
   output logic [1:0]         c_pot,
   output logic [1:0]         c_sel,
   output logic [WIPER_W-1:0] c_data
);
   localparam int          CW   = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

   logic [CW-1:0] cnt;

   assign commit = busy && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         c_pot  <= '0;
         c_sel  <= '0;
         c_data <= '0;
      end else if (go && !busy) begin
         busy   <= 1'b1;
         cnt    <= '0;
         c_pot  <= pot_in;
         c_sel  <= sel_in;
         c_data <= data_in;
      end else if (busy) begin
         if (cnt == LAST) busy <= 1'b0;
         else             cnt  <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
   import dpot_pkg::*;
#(
   parameter int WIPER_W  = 6,
   parameter int NUM_POTS = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  vol_we,
   input  logic [1:0]                            vol_pot,
   input  logic [WIPER_W-1:0]                    vol_data,
   input  logic                                  nv_we,
   input  logic [1:0]                            nv_pot,
   input  logic [1:0]                            nv_sel,
   input  logic [WIPER_W-1:0]                    nv_data,
   output logic [NUM_POTS*WIPER_W-1:0]           wiper_o,
   output logic [NUM_POTS*NV_PER_POT*WIPER_W-1:0] nvreg_o
);
   for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wiper_o[p*WIPER_W +: WIPER_W] <= '0;
         else if (vol_we && (int'(vol_pot) == p))
            wiper_o[p*WIPER_W +: WIPER_W] <= vol_data;
      end
      for (genvar r = 0; r < NV_PER_POT; r++) begin : g_reg
         localparam int BASE = (p*NV_PER_POT + r) * WIPER_W;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               nvreg_o[BASE +: WIPER_W] <= '0;
            else if (nv_we && (int'(nv_pot) == p) && (int'(nv_sel) == r))
               nvreg_o[BASE +: WIPER_W] <= nv_data;
         end
      end
   end
endmodule

// File: rtl/dpot_i2c_wr.sv
module dpot_i2c_wr
   import dpot_pkg::*;
#(
   parameter int         WIPER_W     = 6,
   parameter int         NUM_POTS    = 2,
   parameter int         PROG_CYCLES = 1250000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] DEV_TYPE    = 3'b010
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   scl_i,
   input  logic                                   sda_i,
   output logic                                   sda_drive_low_o,
   input  logic [3:0]                             addr_pins_i,
   output logic [NUM_POTS*WIPER_W-1:0]            wiper_o,
   output logic [NUM_POTS*NV_PER_POT*WIPER_W-1:0] nvreg_o,
   output logic                                   busy_o
);
   if (WIPER_W < 1 || WIPER_W > 8) begin : g_bad_width
      $error("WIPER_W must lie in 1..8");
   end
   if (NUM_POTS < 1 || NUM_POTS > 4) begin : g_bad_pots
      $error("NUM_POTS must lie in 1..4");
   end
   if (PROG_CYCLES < 2) begin : g_bad_prog
      $error("PROG_CYCLES must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_rise, scl_fall, start_p, stop_p, sda_lvl;
   logic vol_we, nv_go, commit;
   logic [1:0] tgt_pot, tgt_sel, c_pot, c_sel;
   logic [WIPER_W-1:0] vol_data, nv_data, c_data;

   dpot_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl));

   dpot_xfer_fsm #(.WIPER_W(WIPER_W), .NUM_POTS(NUM_POTS), .DEV_TYPE(DEV_TYPE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p), .sda_lvl(sda_lvl), .busy(busy_o),
      .addr_pins(addr_pins_i), .sda_low(sda_drive_low_o),
      .vol_we(vol_we), .vol_data(vol_data), .nv_go(nv_go),
      .tgt_pot(tgt_pot), .tgt_sel(tgt_sel), .nv_data(nv_data));

   dpot_prog_timer #(.WIPER_W(WIPER_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(nv_go), .pot_in(tgt_pot), .sel_in(tgt_sel),
      .data_in(nv_data), .busy(busy_o), .commit(commit),
      .c_pot(c_pot), .c_sel(c_sel), .c_data(c_data));

   dpot_regfile #(.WIPER_W(WIPER_W), .NUM_POTS(NUM_POTS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .vol_we(vol_we), .vol_pot(tgt_pot), .vol_data(vol_data),
      .nv_we(commit), .nv_pot(c_pot), .nv_sel(c_sel), .nv_data(c_data),
      .wiper_o(wiper_o), .nvreg_o(nvreg_o));
endmodule

// File: rtl/dpot_i2c_wr_chk.sv
module dpot_i2c_wr_chk #(
   parameter int WIPER_W     = 6,
   parameter int NUM_POTS    = 2,
   parameter int PROG_CYCLES = 1250000
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic                               busy_o,
   input logic                               sda_drive_low_o,
   input logic                               scl_fall,
   input logic                               start_p,
   input logic                               stop_p,
   input logic [NUM_POTS*WIPER_W-1:0]        wiper_o,
   input logic [NUM_POTS*4*WIPER_W-1:0]      nvreg_o
);
   localparam int RW = $clog2(PROG_CYCLES + 2) + 1;
   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_cnt <= '0;
      else if (busy_o) run_cnt <= run_cnt + 1'b1;
      else             run_cnt <= '0;
   end

   // R7: silent while programming
   p_silent_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_drive_low_o);

   // R6: interval length
   p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> (run_cnt == RW'(PROG_CYCLES)));

   // R6: data registers change only at the end of the interval
   p_nv_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy_o) |-> $stable(nvreg_o));

   // R5: wiper changes together with the start of the data acknowledge
   p_wiper_at_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_o) |-> $rose(sda_drive_low_o));

   // R9: acknowledge released only after a clock fall or a bus condition
   p_ack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_drive_low_o) |-> $past(scl_fall || start_p || stop_p));

   // R8: a bus condition leaves SDA released
   p_cond_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_p || stop_p) |=> !sda_drive_low_o);
endmodule

bind dpot_i2c_wr dpot_i2c_wr_chk #(
   .WIPER_W(WIPER_W), .NUM_POTS(NUM_POTS), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .sda_drive_low_o(sda_drive_low_o),
   .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p),
   .wiper_o(wiper_o), .nvreg_o(nvreg_o));

// File: tb/dpot_i2c_wr_test.sv
`timescale 1ns/1ps
module dpot_i2c_wr_test;
   localparam int W    = 6;
   localparam int NP   = 2;
   localparam int PROG = 2000;
   localparam int HALF = 10;
   localparam int WW   = NP*W;
   localparam int NW   = NP*4*W;
   localparam logic [7:0] ADDR = 8'h52; // 010_1001_0

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_drive_low_o, busy_o;
   logic [3:0] pins = 4'b1001;
   logic [WW-1:0] wiper_o;
   logic [NW-1:0] nvreg_o;

   always #2 clk = ~clk;
   assign sda_bus = sda_m & ~sda_drive_low_o;

   dpot_i2c_wr #(.WIPER_W(W), .NUM_POTS(NP), .PROG_CYCLES(PROG)) uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_drive_low_o(sda_drive_low_o), .addr_pins_i(pins),
      .wiper_o(wiper_o), .nvreg_o(nvreg_o), .busy_o(busy_o));

   int n_run = 0, n_fail = 0;
   logic [WW-1:0] mdl_w = '0;
   logic [NW-1:0] mdl_n = '0;
   logic [WW-1:0] exp_w[$];
   logic [NW-1:0] exp_n[$];
   string         exp_tag[$];
   int busy_len = 0, busy_last = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver side of the scoreboard
   task automatic push_wiper(input int pot, input logic [7:0] d, input string tag);
      mdl_w[pot*W +: W] = d[W-1:0];
      exp_w.push_back(mdl_w); exp_n.push_back(mdl_n); exp_tag.push_back(tag);
   endtask
   task automatic push_nv(input int pot, input int r, input logic [7:0] d, input string tag);
      mdl_n[(pot*4+r)*W +: W] = d[W-1:0];
      exp_w.push_back(mdl_w); exp_n.push_back(mdl_n); exp_tag.push_back(tag);
   endtask

   task automatic i2c_start;
      sda_m = 1'b1; wt(HALF/2);
      scl_m = 1'b1; wt(HALF);
      sda_m = 1'b0; wt(HALF);
      scl_m = 1'b0; wt(HALF/2);
   endtask
   task automatic i2c_stop;
      sda_m = 1'b0; wt(HALF/2);
      scl_m = 1'b1; wt(HALF);
      sda_m = 1'b1; wt(HALF);
   endtask
   task automatic send_bits(input logic [7:0] b, input int nb);
      bit clash = 0;
      for (int i = 7; i > 7 - nb; i--) begin
         sda_m = b[i]; wt(HALF/2);
         scl_m = 1'b1; wt(HALF/2);
         if (sda_drive_low_o) clash = 1;
         wt(HALF/2);
         scl_m = 1'b0; wt(HALF/2);
      end
      chk(!clash, "R9 SDA driven during data bits", 64'(clash), 64'd0);
   endtask
   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; wt(HALF/2);
      scl_m = 1'b1; wt(HALF/2);
      ack = (sda_bus == 1'b0);
      wt(HALF/2);
      scl_m = 1'b0; wt(HALF/2);
   endtask
   task automatic txn(input logic [7:0] a, input logic [7:0] i, input logic [7:0] d,
                      output logic [2:0] acks);
      i2c_start;
      send_byte(a, acks[2]);
      send_byte(i, acks[1]);
      send_byte(d, acks[0]);
      i2c_stop;
   endtask

   // monitor side of the scoreboard
   initial begin
      logic [WW-1:0] last_w;
      logic [NW-1:0] last_n;
      last_w = '0; last_n = '0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (wiper_o !== last_w || nvreg_o !== last_n) begin
            if (exp_w.size() == 0) begin
               chk(0, "R4/R8 unexpected register change", 64'(nvreg_o), 64'(last_n));
            end else begin
               logic [WW-1:0] ew;
               logic [NW-1:0] en;
               string t;
               ew = exp_w.pop_front(); en = exp_n.pop_front(); t = exp_tag.pop_front();
               chk(wiper_o === ew, t, 64'(wiper_o), 64'(ew));
               chk(nvreg_o === en, t, 64'(nvreg_o), 64'(en));
            end
            last_w = wiper_o; last_n = nvreg_o;
         end
      end
   end

   // busy interval measurement
   initial begin
      forever begin
         @(negedge clk);
         if (busy_o) busy_len++;
         else if (busy_len != 0) begin busy_last = busy_len; busy_len = 0; end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog expired", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] a;
      logic       ack;
      int         polls;
      wt(5);
      rst_n = 1'b1;
      wt(3);
      // R1
      chk(wiper_o == '0, "R1 wiper reset", 64'(wiper_o), 64'd0);
      chk(nvreg_o == '0, "R1 data reg reset", 64'(nvreg_o), 64'd0);
      chk(!busy_o && !sda_drive_low_o, "R1 busy/sda reset",
          64'({busy_o, sda_drive_low_o}), 64'd0);

      // R3 R5: wiper writes, upper data bits ignored
      push_wiper(0, 8'hC5, "R5 wiper0 upper bits ignored");
      txn(ADDR, 8'hA0, 8'hC5, a);
      chk(a == 3'b111, "R3 acks wiper0 write", 64'(a), 64'h7);
      push_wiper(1, 8'h3F, "R5 wiper1 write");
      txn(ADDR, 8'hA1, 8'h3F, a);
      chk(a == 3'b111, "R3 acks wiper1 write", 64'(a), 64'h7);

      // R2: address mismatches
      txn(8'h5C, 8'hA0, 8'h01, a); // pins 1110
      chk(a == 3'b000, "R2 wrong pins", 64'(a), 64'h0);
      txn(8'h53, 8'hA0, 8'h01, a); // read bit set
      chk(a == 3'b000, "R2 read bit", 64'(a), 64'h0);
      txn(8'h92, 8'hA0, 8'h01, a); // wrong prefix
      chk(a == 3'b000, "R2 wrong prefix", 64'(a), 64'h0);

      // R4: undefined opcode, pot out of range
      txn(ADDR, 8'h30, 8'h07, a);
      chk(a == 3'b100, "R4 undefined opcode", 64'(a), 64'h4);
      txn(ADDR, 8'hA2, 8'h07, a);
      chk(a == 3'b100, "R4 pot select 2", 64'(a), 64'h4);

      // R8: STOP in the middle of the data byte
      i2c_start;
      send_byte(ADDR, ack);
      send_byte(8'hA0, ack);
      send_bits(8'h2B, 4);
      i2c_stop;
      chk(wiper_o[W-1:0] == 6'h05, "R8 mid-byte stop no change", 64'(wiper_o[W-1:0]), 64'h05);
      // R8: repeated START inside the instruction byte, new transaction follows
      push_wiper(1, 8'h11, "R8 write after repeated start");
      i2c_start;
      send_byte(ADDR, ack);
      send_bits(8'hA1, 3);
      i2c_start;
      send_byte(ADDR, a[2]);
      send_byte(8'hA1, a[1]);
      send_byte(8'h11, a[0]);
      i2c_stop;
      chk(a == 3'b111, "R8 acks after repeated start", 64'(a), 64'h7);

      // R6 R7: data register write, pot1 reg2
      push_nv(1, 2, 8'h6A, "R6 commit pot1 reg2");
      txn(ADDR, 8'hC9, 8'h6A, a);
      chk(a == 3'b111, "R3 acks data-register write", 64'(a), 64'h7);
      wt(4);
      chk(busy_o == 1'b1, "R6 busy after stop", 64'(busy_o), 64'd1);
      chk(nvreg_o == '0, "R6 no early commit", 64'(nvreg_o), 64'd0);
      txn(ADDR, 8'hA0, 8'h09, a);
      chk(a == 3'b000, "R7 full write ignored while busy", 64'(a), 64'h0);
      polls = 0;
      ack = 1'b0;
      while (!ack && polls < 40) begin
         i2c_start;
         send_byte(ADDR, ack);
         i2c_stop;
         if (polls == 0) chk(!ack, "R7 first poll refused", 64'(ack), 64'd0);
         polls++;
      end
      chk(ack && !busy_o, "R7 poll acked once idle", 64'({ack, busy_o}), 64'h2);
      chk(busy_last == PROG, "R6 busy length", 64'(busy_last), 64'(PROG));
      chk(nvreg_o[36 +: W] == 6'h2A, "R6 committed value", 64'(nvreg_o[36 +: W]), 64'h2A);

      // R6: second data register, pot0 reg0
      push_nv(0, 0, 8'h15, "R6 commit pot0 reg0");
      txn(ADDR, 8'hC0, 8'h15, a);
      chk(a == 3'b111, "R3 acks second data write", 64'(a), 64'h7);
      wait (busy_o == 1'b0);
      wt(4);
      chk(busy_last == PROG, "R6 busy length second", 64'(busy_last), 64'(PROG));
      chk(exp_w.size() == 0, "R5/R6 all expected updates seen", 64'(exp_w.size()), 64'd0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule